// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves frames from memory to a MAC transmit port under the control of a ring of descriptors that software fills in. Each descriptor takes eight bytes. The first word holds a status half-word and a byte count, and the second word holds the buffer start address. Software marks a descriptor as owned by hardware. The engine then fetches it and streams the buffer bytes to the MAC with the end-of-frame and FCS-append flags. It writes the status back with ownership returned to software, and moves to the next descriptor. A wrap flag closes the ring back to its base address.

When the engine reaches a descriptor that software has not handed over, it halts and waits for software to restart it. A graceful-stop request lets the frame in progress complete, then parks the engine and raises an event. A small register port sets the ring base, the enable and stop controls, and reads back the halt flag and the write-one-to-clear events. The memory side is a single-outstanding request port: the request is held until the response arrives, and a write is acknowledged the same way.

Top module: `txbd_engine`

## Requirements
- R1: After reset the ring base and control registers read 0, the status register reads 0x1 (halted, no events), and no memory request or transmit byte is issued.
- R2: For a descriptor at address D, the engine reads word D, whose bits 31:16 are the status and bits 15:0 the byte count, then word D+4, which is the buffer address. The ready flag is status bit 15.
- R3: The buffer bytes go out in ascending address order, for any start alignment and count. The byte at an address with (address mod 4)==k sits in bits 31-8k down to 24-8k of the aligned memory word. tx_data_o holds while tx_ready_i is low.
- R4: tx_last_o comes with the final byte of a descriptor only when its status bit 11 (last) is set. tx_crc_o follows status bit 10 (FCS append) on each byte of that descriptor.
- R5: After the final byte, the engine writes word D with the status (bit 15 cleared, other bits kept) and the byte count unchanged. A zero-count descriptor sends no bytes and is still written back.
- R6: The next descriptor is at D+8, or at the ring base when status bit 13 (wrap) is set.
- R7: A fetched descriptor with bit 15 clear sets status register bit 0 (halted). It is not written back, and no further fetch or byte is issued. Writing 1 to status bit 0 refetches that same descriptor.
- R8: Control bit 1 (graceful stop) lets the frame in progress complete up to its last-flagged descriptor, then stops fetching and sets status bit 1. If the engine is halted or idle, bit 1 is set at once. Clearing control bit 1 resumes fetching.
- R9: Writing back a descriptor with status bit 12 (interrupt) set raises status register bit 2; descriptors without it leave bit 2 alone.
- R10: Status bits 1 and 2 clear only when 1 is written to them; writing 0 has no effect.
- R11: Register 0 holds the ring base with bits 2:0 forced to 0. While control bit 0 (enable) is low, the descriptor pointer follows the base, so enabling starts at index zero.
- R12: A memory request holds its address, direction and write data until mem_rvalid_i, and is never active in the same cycle as tx_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 base, 1 control, 2 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory request, held until response |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Response or write acknowledge |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | MAC accepts byte |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Final byte of frame |
| tx_crc_o | output | 1 | Append FCS to this frame |

## Verification
The hardest case to reach is a graceful stop that arrives while a frame spanning two descriptors is still streaming, because the request has to land after the first byte and before the closing write-back. The bench throttles tx_ready_i in a fixed pattern to stretch the frame. It polls the captured byte count and writes the stop request as soon as the first byte is accepted. It then checks that both descriptors completed and that the following ready descriptor was left untouched. A near-exhaustive ring of 37 descriptors covers every count from 1 to 9 at all four alignments, plus a zero-count wrap entry.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_BYTES = 8;

  // status half-word flag positions
  localparam int RDY_BIT  = 15;
  localparam int WRAP_BIT = 13;
  localparam int INT_BIT  = 12;
  localparam int LAST_BIT = 11;
  localparam int CRC_BIT  = 10;

  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC, S_PTR, S_RD, S_TX, S_WB, S_HALT, S_STOP
  } state_e;
endpackage

// File: rtl/txbd_byte_sel.sv
module txbd_byte_sel #(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int LW = $clog2(NL)
) (
  input  logic [DW-1:0] word_i,
  input  logic [LW-1:0] lane_i,
  output logic [7:0]    byte_o
);
  logic [7:0] lanes [NL];

  // lowest address in the most significant byte
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lanes[g] = word_i[DW-1-8*g -: 8];
  end

  assign byte_o = lanes[lane_i];
endmodule

// File: rtl/txbd_regs.sv
module txbd_regs
  import txbd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          halt_set_i,
  input  logic          stop_set_i,
  input  logic          frame_set_i,
  output logic [AW-1:0] base_o,
  output logic          en_o,
  output logic          gstop_o,
  output logic          halted_o
);
  logic [AW-1:0] base_q;
  logic en_q, gstop_q, halted_q, stop_evt_q, frame_evt_q;
  logic stat_wr;

  assign stat_wr = we_i && (addr_i == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q      <= '0;
      en_q        <= 1'b0;
      gstop_q     <= 1'b0;
      halted_q    <= 1'b1;
      stop_evt_q  <= 1'b0;
      frame_evt_q <= 1'b0;
    end else begin
      if (we_i && addr_i == REG_BASE) base_q <= {wdata_i[AW-1:3], 3'b000};
      if (we_i && addr_i == REG_CTRL) begin
        en_q    <= wdata_i[0];
        gstop_q <= wdata_i[1];
      end
      // hardware set wins over a same-cycle clear
      if (halt_set_i)                   halted_q <= 1'b1;
      else if (stat_wr && wdata_i[0])   halted_q <= 1'b0;
      if (stop_set_i)                   stop_evt_q <= 1'b1;
      else if (stat_wr && wdata_i[1])   stop_evt_q <= 1'b0;
      if (frame_set_i)                  frame_evt_q <= 1'b1;
      else if (stat_wr && wdata_i[2])   frame_evt_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      REG_BASE: rdata_o = 32'(base_q);
      REG_CTRL: rdata_o = {30'b0, gstop_q, en_q};
      REG_STAT: rdata_o = {29'b0, frame_evt_q, stop_evt_q, halted_q};
      default:  rdata_o = '0;
    endcase
  end

  assign base_o   = base_q;
  assign en_o     = en_q;
  assign gstop_o  = gstop_q;
  assign halted_o = halted_q;
endmodule

// File: rtl/txbd_fsm.sv
module txbd_fsm
  import txbd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     base_i,
  input  logic              en_i,
  input  logic              gstop_i,
  input  logic              halted_i,
  output logic              halt_set_o,
  output logic              stop_set_o,
  output logic              frame_set_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [WORD_W-1:0] word_o,
  output logic [1:0]        lane_o,
  output logic              tx_last_o,
  output logic              tx_crc_o
);
  state_e state_q, state_d, nxt_closed, nxt_open;
  logic [AW-1:0] cur_q, ptr_q, byte_addr;
  logic [15:0]   stat_q, len_q, cnt_q;
  logic [WORD_W-1:0] word_q;
  logic in_frame_q, last_byte;
  logic [15:0] rd_stat;

  assign rd_stat   = mem_rdata_i[31:16];
  assign byte_addr = ptr_q + AW'(cnt_q);
  assign last_byte = (cnt_q == len_q - 16'd1);

  // decision taken at a descriptor boundary
  always_comb begin
    if (!en_i)        nxt_closed = S_IDLE;
    else if (gstop_i) nxt_closed = S_STOP;
    else if (halted_i) nxt_closed = S_HALT;
    else              nxt_closed = S_DESC;
    if (!en_i)        nxt_open = S_IDLE;
    else if (halted_i) nxt_open = S_HALT;
    else              nxt_open = S_DESC;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (en_i) state_d = nxt_closed;
      S_DESC: if (mem_rvalid_i) state_d = rd_stat[RDY_BIT] ? S_PTR : S_HALT;
      S_PTR:  if (mem_rvalid_i) state_d = (len_q == 16'd0) ? S_WB : S_RD;
      S_RD:   if (mem_rvalid_i) state_d = S_TX;
      S_TX: begin
        if (tx_ready_i) begin
          if (last_byte)                  state_d = S_WB;
          else if (byte_addr[1:0] == 2'd3) state_d = S_RD;
        end
      end
      S_WB:   if (mem_rvalid_i) state_d = stat_q[LAST_BIT] ? nxt_closed : nxt_open;
      S_HALT: begin
        if (!en_i)                         state_d = S_IDLE;
        else if (gstop_i && !in_frame_q)   state_d = S_STOP;
        else if (!halted_i)                state_d = S_DESC;
      end
      S_STOP: if (!gstop_i || !en_i) state_d = nxt_closed;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cur_q      <= '0;
      ptr_q      <= '0;
      stat_q     <= '0;
      len_q      <= '0;
      cnt_q      <= '0;
      word_q     <= '0;
      in_frame_q <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        S_IDLE: begin
          cur_q      <= base_i;
          in_frame_q <= 1'b0;
        end
        S_DESC: if (mem_rvalid_i) begin
          stat_q <= rd_stat;
          len_q  <= mem_rdata_i[15:0];
        end
        S_PTR: if (mem_rvalid_i) begin
          ptr_q <= mem_rdata_i[AW-1:0];
          cnt_q <= '0;
        end
        S_RD: if (mem_rvalid_i) word_q <= mem_rdata_i;
        S_TX: if (tx_ready_i) cnt_q <= cnt_q + 16'd1;
        S_WB: if (mem_rvalid_i) begin
          cur_q      <= stat_q[WRAP_BIT] ? base_i : cur_q + AW'(DESC_BYTES);
          in_frame_q <= !stat_q[LAST_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = cur_q;
    case (state_q)
      S_DESC: mem_req_o = 1'b1;
      S_PTR: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(4);
      end
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {byte_addr[AW-1:2], 2'b00};
      end
      S_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_wdata_o = {stat_q & ~(16'h1 << RDY_BIT), len_q};
  assign tx_valid_o  = (state_q == S_TX);
  assign tx_last_o   = tx_valid_o && last_byte && stat_q[LAST_BIT];
  assign tx_crc_o    = tx_valid_o && stat_q[CRC_BIT];
  assign word_o      = word_q;
  assign lane_o      = byte_addr[1:0];

  assign halt_set_o  = (state_q == S_DESC) && mem_rvalid_i && !rd_stat[RDY_BIT];
  assign frame_set_o = (state_q == S_WB) && mem_rvalid_i && stat_q[INT_BIT];
  assign stop_set_o  = (state_d == S_STOP) && (state_q != S_STOP);
endmodule

// File: rtl/txbd_engine.sv
module txbd_engine
  import txbd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  output logic          tx_crc_o
);
  logic [AW-1:0] base_w;
  logic en_w, gstop_w, halted_w;
  logic halt_set_w, stop_set_w, frame_set_w;
  logic [WORD_W-1:0] word_w;
  logic [1:0] lane_w;

  txbd_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .halt_set_i(halt_set_w), .stop_set_i(stop_set_w), .frame_set_i(frame_set_w),
    .base_o(base_w), .en_o(en_w), .gstop_o(gstop_w), .halted_o(halted_w)
  );

  txbd_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni,
    .base_i(base_w), .en_i(en_w), .gstop_i(gstop_w), .halted_i(halted_w),
    .halt_set_o(halt_set_w), .stop_set_o(stop_set_w), .frame_set_o(frame_set_w),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rvalid_i, .mem_rdata_i,
    .tx_valid_o, .tx_ready_i, .word_o(word_w), .lane_o(lane_w),
    .tx_last_o, .tx_crc_o
  );

  txbd_byte_sel #(.DW(WORD_W)) u_sel (
    .word_i(word_w), .lane_i(lane_w), .byte_o(tx_data_o)
  );
endmodule

// File: rtl/txbd_engine_chk.sv
module txbd_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_rvalid_i,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [7:0]    tx_data_o,
  input logic          tx_last_o,
  input logic          halted_i
);
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R12
  req_tx_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && tx_valid_o));

  // R3
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R4
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  // R5
  wb_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);

  // R7
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_i) |-> !mem_req_o && !tx_valid_o);
endmodule

bind txbd_engine txbd_engine_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .tx_last_o(tx_last_o), .halted_i(halted_w)
);

// File: tb/txbd_engine_test.sv
`timescale 1ns/1ps
module txbd_engine_test;
  localparam int AW = 32;
  localparam logic [15:0] F_RDY = 16'h8000, F_WRAP = 16'h2000, F_INT = 16'h1000,
                          F_LAST = 16'h0800, F_CRC = 16'h0400;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic mem_req_o, mem_we_o, mem_rvalid_i;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;
  logic tx_valid_o, tx_ready_i, tx_last_o, tx_crc_o;
  logic [7:0] tx_data_o;

  always #4 clk_i = ~clk_i;

  txbd_engine #(.AW(AW)) uut (.*);

  int errors = 0, checks = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // memory model, single writer
  logic [31:0] mem [0:255];
  logic tb_we = 1'b0;
  logic [7:0] tb_wa = '0;
  logic [31:0] tb_wd = '0;
  logic rv_q = 1'b0;
  logic [31:0] rd_q = '0;
  assign mem_rvalid_i = rv_q;
  assign mem_rdata_i  = rd_q;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++)
        mem[i] <= {pat(4*i), pat(4*i+1), pat(4*i+2), pat(4*i+3)};
      rv_q <= 1'b0;
    end else begin
      if (tb_we) mem[tb_wa] <= tb_wd;
      if (mem_req_o && !rv_q) begin
        rv_q <= 1'b1;
        rd_q <= mem[mem_addr_o[9:2]];
        if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
      end else rv_q <= 1'b0;
    end
  end

  // byte sink with optional backpressure
  logic bp_en = 1'b0;
  int rcnt = 0;
  always @(negedge clk_i) begin
    rcnt <= rcnt + 1;
    tx_ready_i <= bp_en ? (rcnt % 3 != 0) : 1'b1;
  end

  logic [7:0] cap_data [0:1023];
  logic cap_last [0:1023];
  logic cap_crc [0:1023];
  int cap_n = 0;
  always @(posedge clk_i) begin
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      cap_data[cap_n] <= tx_data_o;
      cap_last[cap_n] <= tx_last_o;
      cap_crc[cap_n]  <= tx_crc_o;
      cap_n <= cap_n + 1;
    end
  end

  // handshake monitor
  int hs_err = 0;
  logic pend = 1'b0;
  logic [AW-1:0] p_addr = '0;
  always @(posedge clk_i) begin
    if (rst_ni && pend && !(mem_req_o && mem_addr_o == p_addr)) hs_err <= hs_err + 1;
    pend   <= rst_ni && mem_req_o && !mem_rvalid_i;
    p_addr <= mem_addr_o;
  end

  // descriptor bookkeeping in the bench
  int d_addr [0:63];
  logic [15:0] d_stat [0:63], d_len [0:63];
  int d_ptr [0:63];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mw(input int addr, input logic [31:0] d);
    @(negedge clk_i);
    tb_we = 1'b1; tb_wa = 8'(addr >> 2); tb_wd = d;
    @(negedge clk_i);
    tb_we = 1'b0;
  endtask

  task automatic set_desc(input int s, input int addr, input logic [15:0] st,
                          input logic [15:0] ln, input int p);
    d_addr[s] = addr; d_stat[s] = st; d_len[s] = ln; d_ptr[s] = p;
    mw(addr, {st, ln});
    mw(addr + 4, 32'(p));
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_stat(input logic [31:0] mask, input string req);
    logic [31:0] v;
    int n = 0;
    reg_rd(2'd2, v);
    while ((v & mask) == 0 && n < 8000) begin
      reg_rd(2'd2, v);
      n++;
    end
    chk((v & mask) != 0, req, v, mask);
  endtask

  task automatic verify(input int lo, input int hi, input int start, input string req);
    int p = start;
    for (int s = lo; s <= hi; s++) begin
      bit ok = 1'b1;
      longint act = 0, exp = 0;
      for (int j = 0; j < int'(d_len[s]); j++) begin
        logic [7:0] eb = pat(d_ptr[s] + j);
        logic el = (j == int'(d_len[s]) - 1) && ((d_stat[s] & F_LAST) != 0);
        logic ec = (d_stat[s] & F_CRC) != 0;
        if (ok && (cap_data[p] !== eb || cap_last[p] !== el || cap_crc[p] !== ec)) begin
          ok = 1'b0;
          act = {cap_data[p], 3'b0, cap_last[p], 3'b0, cap_crc[p]};
          exp = {eb, 3'b0, el, 3'b0, ec};
        end
        p++;
      end
      chk(ok, {req, " R3 R4 bytes"}, act, exp);
      chk(mem[d_addr[s] >> 2] === {d_stat[s] & ~F_RDY, d_len[s]}, {req, " R5 writeback"},
          mem[d_addr[s] >> 2], {d_stat[s] & ~F_RDY, d_len[s]});
    end
    chk(cap_n == p, {req, " R3 byte count"}, cap_n, p);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1
    reg_rd(2'd0, v); chk(v == 0, "R1 base", v, 0);
    reg_rd(2'd1, v); chk(v == 0, "R1 ctrl", v, 0);
    reg_rd(2'd2, v); chk(v == 1, "R1 status", v, 1);
    chk(!mem_req_o && !tx_valid_o, "R1 quiet", {mem_req_o, tx_valid_o}, 0);

    // R2 R3 R4 R5 R6: ring of every count 1..9 at every alignment, then zero count with wrap
    for (int k = 0; k < 36; k++) begin
      logic [15:0] st = F_RDY;
      if (k % 3 != 1) st |= F_LAST;
      if (k % 2 == 1) st |= F_CRC;
      set_desc(k, 8 * k, st, 16'(1 + k % 9), 32'h200 + 12 * k + k / 9);
    end
    set_desc(36, 8 * 36, F_RDY | F_LAST | F_WRAP, 16'd0, 32'h300);
    bp_en = 1'b1;
    reg_wr(2'd1, 32'h1);
    c0 = cap_n;
    reg_wr(2'd2, 32'h1);
    wait_stat(32'h1, "R7 halt after ring");
    verify(0, 36, c0, "ring R2");
    reg_rd(2'd2, v); chk(v == 1, "R9 no interrupt flag", v, 1);

    // R7: stays halted
    c0 = cap_n;
    repeat (30) @(negedge clk_i);
    reg_rd(2'd2, v); chk(v == 1, "R7 still halted", v, 1);
    chk(cap_n == c0, "R7 no bytes while halted", cap_n, c0);
    chk(mem[0] === {d_stat[0] & ~F_RDY, d_len[0]}, "R7 no writeback on empty", mem[0], 0);

    // R6: wrap returned to base, restart refetches descriptor 0
    set_desc(37, 0, F_RDY | F_LAST, 16'd2, 32'h3F0);
    c0 = cap_n;
    reg_wr(2'd2, 32'h1);
    wait_stat(32'h1, "R7 halt at index one");
    verify(37, 37, c0, "wrap R6");

    // R9 R10
    set_desc(38, 8, F_RDY | F_LAST | F_INT, 16'd3, 32'h301);
    c0 = cap_n;
    reg_wr(2'd2, 32'h1);
    wait_stat(32'h4, "R9 interrupt event");
    wait_stat(32'h1, "R7 halt after interrupt frame");
    verify(38, 38, c0, "irq R9");
    reg_rd(2'd2, v); chk(v == 5, "R9 status", v, 5);
    reg_wr(2'd2, 32'h0);
    reg_rd(2'd2, v); chk(v == 5, "R10 zero write", v, 5);
    reg_wr(2'd2, 32'h4);
    reg_rd(2'd2, v); chk(v == 1, "R10 clear frame event", v, 1);

    // R8: stop request during a two-descriptor frame
    set_desc(39, 16, F_RDY, 16'd9, 32'h280);
    set_desc(40, 24, F_RDY | F_LAST | F_CRC, 16'd4, 32'h2A3);
    set_desc(41, 32, F_RDY | F_LAST, 16'd3, 32'h2C2);
    c0 = cap_n;
    reg_wr(2'd2, 32'h1);
    while (cap_n == c0) @(negedge clk_i);
    reg_wr(2'd1, 32'h3);
    wait_stat(32'h2, "R8 stop event");
    repeat (20) @(negedge clk_i);
    verify(39, 40, c0, "stop R8");
    chk(mem[32 >> 2][31] === 1'b1, "R8 next descriptor untouched", mem[32 >> 2], {F_RDY, 16'd3});
    reg_rd(2'd2, v); chk(v == 2, "R8 stopped not halted", v, 2);
    reg_wr(2'd2, 32'h2);
    reg_rd(2'd2, v); chk(v == 0, "R10 clear stop event", v, 0);
    c0 = cap_n;
    reg_wr(2'd1, 32'h1);
    wait_stat(32'h1, "R8 resume then halt");
    verify(41, 41, c0, "resume R8");

    // R8: stop while halted is immediate
    c0 = cap_n;
    reg_wr(2'd1, 32'h3);
    repeat (2) @(negedge clk_i);
    reg_rd(2'd2, v); chk(v == 3, "R8 stop while halted", v, 3);
    reg_wr(2'd1, 32'h1);
    reg_wr(2'd2, 32'h2);
    reg_rd(2'd2, v); chk(v == 1, "R8 back to halted", v, 1);
    chk(cap_n == c0, "R8 no bytes while stopped", cap_n, c0);

    // R11: new base, restart from index zero
    reg_wr(2'd1, 32'h0);
    reg_wr(2'd0, 32'h187);
    reg_rd(2'd0, v); chk(v == 32'h180, "R11 base alignment", v, 32'h180);
    set_desc(42, 32'h180, F_RDY | F_LAST | F_WRAP, 16'd5, 32'h241);
    bp_en = 1'b0;
    reg_wr(2'd1, 32'h1);
    c0 = cap_n;
    reg_wr(2'd2, 32'h1);
    wait_stat(32'h1, "R11 halt after rebased frame");
    verify(42, 42, c0, "rebase R11");

    // R12
    chk(hs_err == 0, "R12 request held until response", hs_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule